// File: doc/BRIEF.md
# Serial Flash Status Protection Controller

This block is the command and protection logic of a serial flash slave. It covers only status-register writes and a secured one-time-programmable (OTP) sector mode. It watches chip-select, serial clock and serial data-in in SPI mode 0 or mode 3. It decodes a small set of single-byte commands: two write-enable variants, write-disable, status write, status read and OTP entry. It holds the three block-protect bits, a protection lock bit, the write-enable latch and an OTP lock flag.

A write-protect input pin limits what a status write may change. When the block is in OTP mode, a status write does not alter the protection bits. Instead it seals the OTP sector for good. An external array controller reads `otp_mode` to route accesses to the OTP sector, and `otp_prog_ok` to decide whether an OTP program may start. The array and its program timing live outside this block. The array controller reports its busy state back on `array_busy`.

All SPI pins are synchronised into the system clock. The system clock must run at least eight times faster than the serial clock. Status read data leaves on `spi_miso`, and `spi_miso_oe` drives the pad's tri-state enable, so the pin floats except while status is being shifted out.

Top module: `spi_status_guard`

## Requirements
- R1: The status byte reads as lock at bit 7, zeros at bits 6 and 5, block-protect bits 2..0 at bits 4..2, write-enable latch at bit 1 and `array_busy` at bit 0. A status write can change only bit 7 and bits 4..2.
- R2: Protection bits, latch and mode flags change only in the cycles that follow the chip-select rise ending a frame. They never change while the frame is still in progress.
- R3: A status write (0x01, then a data byte) takes effect only if the write-enable latch was set in an earlier frame, by 0x06 or by 0x50. A single-byte command counts only when it is the one whole byte of its frame.
- R4: With `wp_n` low and lock at 1, a status write leaves the lock and block-protect bits unchanged.
- R5: With `wp_n` low and lock at 0, a status write may set lock to 1. Lock never falls from 1 to 0 while `wp_n` is low.
- R6: With `wp_n` high, one status write may freely set or clear lock and all three block-protect bits at once.
- R7: Any completed status write, accepted or ignored, clears the write-enable latch. Write-disable (0x04) also clears it.
- R8: After the 0x05 opcode, the status byte is shifted out MSB first, each bit launched on a falling serial-clock edge, and it repeats for as long as clocks continue. `spi_miso_oe` is low at all other times.
- R9: A chip-select rise after a partial byte aborts the frame with no change to any state.
- R10: Opcode 0xB1 sets `otp_mode`.
- R11: In OTP mode, an enabled status write discards its data and sets the OTP lock, which is never cleared afterwards.
- R12: OTP mode is left only by write-disable (0x04). Other commands leave `otp_mode` at 1.
- R13: `otp_prog_ok` is high exactly when `otp_mode` is 1, the OTP lock is 0 and all three block-protect bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in, sampled on rising clock |
| wp_n | input | 1 | Write-protect pin, active low |
| array_busy | input | 1 | Array controller busy, mirrored to status bit 0 |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the serial-out pad |
| otp_mode | output | 1 | OTP sector selected |
| otp_prog_ok | output | 1 | OTP program permitted |

## Verification
The bench targets the write-protect and lock interaction. A design that tested only `wp_n`, or only the lock bit, would accept a write to a locked register or refuse a write with the pin high. It sends an enable and a status write inside one frame, which a decoder that accepts a command mid-frame would wrongly act on. It cuts frames after a partial byte; a design that executes on any chip-select rise would then change the protection bits. In OTP mode it checks three things. The data byte must be thrown away rather than written. The OTP seal must survive leaving and re-entering the mode. Only write-disable may end the mode.

// File: rtl/spi_sr_pkg.sv
// Package: shared command codes and status bit positions for the
// status protection controller. Assumes 8-bit commands, MSB first.
package spi_sr_pkg;
    localparam logic [7:0] OP_WRSR = 8'h01;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_EWSR = 8'h50;
    localparam logic [7:0] OP_ENSO = 8'hB1;

    localparam int BYTE_W  = 8;
    localparam int BP_W    = 3;
    localparam int BP_LSB  = 2;
    localparam int LOCK_B  = 7;
    localparam int CNT_W   = $clog2(BYTE_W);

    // Number of whole bytes seen in a frame, saturating at two.
    typedef enum logic [1:0] {
        NB_NONE = 2'd0,
        NB_ONE  = 2'd1,
        NB_MORE = 2'd2
    } nbytes_e;
endpackage

// File: rtl/spi_sr_sync.sv
// Module: multi-bit level synchroniser bank.
// Each input bit passes through STAGES flops (STAGES must be 2 or more).
// Assumes inputs are slow levels relative to clk; reset value per bit
// is given by RST_VAL so idle levels do not create false edges.
module spi_sr_sync #(
    parameter int              STAGES  = 2,
    parameter int              NSIG    = 4,
    parameter logic [NSIG-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSIG-1:0] raw_in,
    output logic [NSIG-1:0] sync_out
);
    for (genvar g = 0; g < NSIG; g++) begin : g_sig
        logic [STAGES-1:0] chain;

        // Shift one input bit through its synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[g]}};
            end else begin
                chain <= {chain[STAGES-2:0], raw_in[g]};
            end
        end

        assign sync_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_sr_rx.sv
// Module: serial byte receiver.
// Detects serial-clock edges while chip select is low, assembles bytes
// MSB first on rising edges and reports frame end with a flag telling
// whether the frame ended on a byte boundary. Assumes synchronised inputs.
module spi_sr_rx
    import spi_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    output logic              sck_fall,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_dat,
    output logic              frame_end,
    output logic              frame_clean
);
    logic              sck_d;
    logic              cs_d;
    logic              sck_rise;
    logic              cs_rise;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-2:0] shreg;

    assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
    assign sck_fall = ~sck_s & sck_d & ~cs_n_s;
    assign cs_rise  = cs_n_s & ~cs_d;

    // Keep the previous clock and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    // Shift data bits in and count position within the current byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
        end else if (cs_n_s) begin
            bit_cnt <= '0;
        end else if (sck_rise) begin
            shreg   <= {shreg[BYTE_W-3:0], mosi_s};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Report complete bytes and frame ends as one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld    <= 1'b0;
            byte_dat    <= '0;
            frame_end   <= 1'b0;
            frame_clean <= 1'b0;
        end else begin
            byte_vld    <= sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1));
            if (sck_rise && (bit_cnt == CNT_W'(BYTE_W - 1))) begin
                byte_dat <= {shreg, mosi_s};
            end
            frame_end   <= cs_rise;
            frame_clean <= (bit_cnt == '0);
        end
    end
endmodule

// File: rtl/spi_sr_ctrl.sv
// Module: command decoder and protection state.
// Records opcode and first data byte per frame, then applies the command
// on the frame end pulse only if the frame ended on a byte boundary.
// Assumes frame_end follows the final byte_vld of the frame.
module spi_sr_ctrl
    import spi_sr_pkg::*;
#(
    parameter logic [BP_W-1:0] BP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              frame_end,
    input  logic              frame_clean,
    input  logic              wp_n_s,
    output logic [BP_W-1:0]   bp_o,
    output logic              lock_o,
    output logic              wel_o,
    output logic              otp_mode_o,
    output logic              otp_lock_o,
    output logic              rd_active_o
);
    logic [BYTE_W-1:0] opcode_q;
    logic [BP_W-1:0]   dat_bp_q;
    logic              dat_lock_q;
    nbytes_e           nbytes_q;

    logic [BP_W-1:0]   bp_q, bp_n;
    logic              lock_q, lock_n;
    logic              wel_q, wel_n;
    logic              otp_mode_q, otp_mode_n;
    logic              otp_lock_q, otp_lock_n;
    logic              rd_active_q;
    logic              exec;
    logic              single;

    assign exec   = frame_end && frame_clean;
    assign single = (nbytes_q == NB_ONE);

    // Capture opcode and data fields and count whole bytes per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode_q    <= '0;
            dat_bp_q    <= '0;
            dat_lock_q  <= 1'b0;
            nbytes_q    <= NB_NONE;
            rd_active_q <= 1'b0;
        end else if (frame_end) begin
            nbytes_q    <= NB_NONE;
            rd_active_q <= 1'b0;
        end else if (byte_vld) begin
            case (nbytes_q)
                NB_NONE: begin
                    opcode_q    <= byte_dat;
                    rd_active_q <= (byte_dat == OP_RDSR);
                    nbytes_q    <= NB_ONE;
                end
                NB_ONE: begin
                    dat_bp_q   <= byte_dat[BP_LSB +: BP_W];
                    dat_lock_q <= byte_dat[LOCK_B];
                    nbytes_q   <= NB_MORE;
                end
                default: nbytes_q <= NB_MORE;
            endcase
        end
    end

    // Work out the protection state after a clean frame end.
    always_comb begin
        bp_n       = bp_q;
        lock_n     = lock_q;
        wel_n      = wel_q;
        otp_mode_n = otp_mode_q;
        otp_lock_n = otp_lock_q;
        if (exec) begin
            case (opcode_q)
                OP_WREN, OP_EWSR: begin
                    if (single) wel_n = 1'b1;
                end
                OP_WRDI: begin
                    if (single) begin
                        wel_n      = 1'b0;
                        otp_mode_n = 1'b0;
                    end
                end
                OP_ENSO: begin
                    if (single) otp_mode_n = 1'b1;
                end
                OP_WRSR: begin
                    if (nbytes_q == NB_MORE) begin
                        wel_n = 1'b0;
                        if (wel_q) begin
                            if (otp_mode_q) begin
                                otp_lock_n = 1'b1;
                            end else if (wp_n_s || !lock_q) begin
                                bp_n   = dat_bp_q;
                                lock_n = dat_lock_q;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Commit the protection state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q       <= BP_RESET;
            lock_q     <= 1'b0;
            wel_q      <= 1'b0;
            otp_mode_q <= 1'b0;
            otp_lock_q <= 1'b0;
        end else begin
            bp_q       <= bp_n;
            lock_q     <= lock_n;
            wel_q      <= wel_n;
            otp_mode_q <= otp_mode_n;
            otp_lock_q <= otp_lock_n;
        end
    end

    assign bp_o        = bp_q;
    assign lock_o      = lock_q;
    assign wel_o       = wel_q;
    assign otp_mode_o  = otp_mode_q;
    assign otp_lock_o  = otp_lock_q;
    assign rd_active_o = rd_active_q;

    // Protection bits move only right after a frame end.
    assert_bp_at_frame_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bp_q) |-> $past(frame_end));

    // Locked register with the pin low keeps its block-protect bits.
    assert_locked_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!wp_n_s && lock_q) |-> $stable(bp_q));

    // Lock can fall only when the pin was high.
    assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> $past(wp_n_s));

    // A frame cut mid-byte changes nothing.
    assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_end && !frame_clean) |->
            ($stable(bp_q) && $stable(lock_q) && $stable(wel_q) && $stable(otp_mode_q)));

    // The OTP seal never clears.
    assert_otp_lock_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(otp_lock_q) |-> otp_lock_q);

    // OTP mode ends only through write-disable.
    assert_otp_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(otp_mode_q) |-> $past(frame_end && opcode_q == OP_WRDI));
endmodule

// File: rtl/spi_sr_tx.sv
// Module: status shifter for serial-out.
// While a status read is active, launches one status bit per falling
// serial-clock edge, MSB first, wrapping every byte. Output enable drops
// as soon as the synchronised chip select goes high.
module spi_sr_tx
    import spi_sr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_fall,
    input  logic              rd_active,
    input  logic [BYTE_W-1:0] status,
    output logic              miso,
    output logic              miso_oe
);
    logic [CNT_W-1:0] idx_q;

    // Step through the status byte on each falling edge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= CNT_W'(BYTE_W - 1);
            miso    <= 1'b0;
            miso_oe <= 1'b0;
        end else if (cs_n_s) begin
            idx_q   <= CNT_W'(BYTE_W - 1);
            miso    <= 1'b0;
            miso_oe <= 1'b0;
        end else if (sck_fall && rd_active) begin
            miso    <= status[idx_q];
            idx_q   <= idx_q - 1'b1;
            miso_oe <= 1'b1;
        end
    end

    // Serial-out is driven only inside a selected frame.
    assert_oe_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !$past(cs_n_s));
endmodule

// File: rtl/spi_status_guard.sv
// Module: top of the status protection controller.
// Synchronises the serial pins, receives bytes, decodes commands,
// holds protection state and returns status on serial-out.
// Assumes clk is at least eight times the serial clock rate.
module spi_status_guard
    import spi_sr_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [BP_W-1:0] BP_RESET    = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    input  logic wp_n,
    input  logic array_busy,
    output logic spi_miso,
    output logic spi_miso_oe,
    output logic otp_mode,
    output logic otp_prog_ok
);
    localparam int NSIG = 4;
    localparam logic [NSIG-1:0] PIN_IDLE = 4'b1001;

    logic [NSIG-1:0]   pins_s;
    logic              sck_fall;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_dat;
    logic              frame_end;
    logic              frame_clean;
    logic [BP_W-1:0]   bp;
    logic              lock;
    logic              wel;
    logic              otp_lock;
    logic              rd_active;
    logic [BYTE_W-1:0] status;

    spi_sr_sync #(
        .STAGES  (SYNC_STAGES),
        .NSIG    (NSIG),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   ({wp_n, spi_mosi, spi_sck, spi_cs_n}),
        .sync_out (pins_s)
    );

    spi_sr_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_s      (pins_s[0]),
        .sck_s       (pins_s[1]),
        .mosi_s      (pins_s[2]),
        .sck_fall    (sck_fall),
        .byte_vld    (byte_vld),
        .byte_dat    (byte_dat),
        .frame_end   (frame_end),
        .frame_clean (frame_clean)
    );

    spi_sr_ctrl #(
        .BP_RESET (BP_RESET)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_vld    (byte_vld),
        .byte_dat    (byte_dat),
        .frame_end   (frame_end),
        .frame_clean (frame_clean),
        .wp_n_s      (pins_s[3]),
        .bp_o        (bp),
        .lock_o      (lock),
        .wel_o       (wel),
        .otp_mode_o  (otp_mode),
        .otp_lock_o  (otp_lock),
        .rd_active_o (rd_active)
    );

    assign status = {lock, 2'b00, bp, wel, array_busy};

    spi_sr_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pins_s[0]),
        .sck_fall  (sck_fall),
        .rd_active (rd_active),
        .status    (status),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    assign otp_prog_ok = otp_mode && !otp_lock && (bp == '0);

    // Program permission never coexists with any block-protect bit set.
    assert_prog_gate_R13: assert property (@(posedge clk) disable iff (!rst_n)
        otp_prog_ok |-> (status[BP_LSB +: BP_W] == '0) && otp_mode);
endmodule

// File: tb/spi_status_guard_bench.sv
module spi_status_guard_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_sck = 1'b0;
    logic spi_mosi = 1'b0;
    logic wp_n = 1'b1;
    logic array_busy = 1'b0;
    logic spi_miso;
    logic spi_miso_oe;
    logic otp_mode;
    logic otp_prog_ok;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic oe_seen;

    always #2.5 clk = ~clk;

    spi_status_guard u_spi_status_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .wp_n        (wp_n),
        .array_busy  (array_busy),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .otp_mode    (otp_mode),
        .otp_prog_ok (otp_prog_ok)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = tx[7-i];
            #40;
            rx[7-i] = spi_miso;
            oe_seen = spi_miso_oe;
            spi_sck = 1'b1;
            #40;
            spi_sck = 1'b0;
        end
    endtask

    task automatic cs_low();
        spi_cs_n = 1'b0;
        #40;
    endtask

    task automatic cs_high();
        #40;
        spi_cs_n = 1'b1;
        #100;
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        cs_low();
        xfer(op, 8, d);
        cs_high();
    endtask

    task automatic wrsr(input logic [7:0] val);
        logic [7:0] d;
        cs_low();
        xfer(8'h01, 8, d);
        xfer(val, 8, d);
        cs_high();
    endtask

    task automatic read_sr(output logic [7:0] v);
        logic [7:0] d;
        cs_low();
        xfer(8'h05, 8, d);
        xfer(8'h00, 8, v);
        cs_high();
    endtask

    task automatic t_reset();
        check("R8 oe idle after reset", {7'd0, spi_miso_oe}, 8'h00);
        check("R10 otp_mode after reset", {7'd0, otp_mode}, 8'h00);
        check("R13 prog_ok after reset", {7'd0, otp_prog_ok}, 8'h00);
        begin
            logic [7:0] v;
            read_sr(v);
            check("R1 status after reset", v, 8'h00);
        end
    endtask

    task automatic t_enable_rules();
        logic [7:0] v;
        logic [7:0] d;
        wrsr(8'h1C);
        read_sr(v);
        check("R3 write without enable ignored", v, 8'h00);
        cmd1(8'h06);
        read_sr(v);
        check("R1 latch shows at bit 1", v, 8'h02);
        wrsr(8'hFF);
        read_sr(v);
        check("R1 R7 only lock and bp written, latch cleared", v, 8'h9C);
        cmd1(8'h50);
        wrsr(8'h00);
        read_sr(v);
        check("R3 R6 alternate enable, lock cleared with pin high", v, 8'h00);
        // enable and write sharing one frame must do nothing
        cs_low();
        xfer(8'h06, 8, d);
        xfer(8'h01, 8, d);
        xfer(8'h1C, 8, d);
        cs_high();
        read_sr(v);
        check("R3 enable inside write frame ignored", v, 8'h00);
    endtask

    task automatic t_wp_lock();
        logic [7:0] v;
        wp_n = 1'b0;
        cmd1(8'h06);
        wrsr(8'h88);
        read_sr(v);
        check("R5 lock set while pin low", v, 8'h88);
        cmd1(8'h06);
        read_sr(v);
        check("R7 latch set before locked write", v, 8'h8A);
        wrsr(8'h00);
        read_sr(v);
        check("R4 R7 locked write ignored and latch cleared", v, 8'h88);
        wp_n = 1'b1;
        #100;
        cmd1(8'h06);
        wrsr(8'h04);
        read_sr(v);
        check("R6 unlock and rewrite with pin high", v, 8'h04);
        cmd1(8'h06);
        cmd1(8'h04);
        read_sr(v);
        check("R7 write-disable clears latch", v, 8'h04);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        logic [7:0] d;
        cmd1(8'h06);
        cs_low();
        xfer(8'h01, 8, d);
        xfer(8'h18, 5, d);
        cs_high();
        read_sr(v);
        check("R9 partial data byte aborts write", v, 8'h06);
        cmd1(8'h04);
        cs_low();
        xfer(8'h06, 4, d);
        cs_high();
        read_sr(v);
        check("R9 partial enable has no effect", v, 8'h04);
    endtask

    task automatic t_read_path();
        logic [7:0] v;
        logic [7:0] d;
        array_busy = 1'b1;
        read_sr(v);
        check("R1 busy shows at bit 0", v, 8'h05);
        check("R8 oe driven during read", {7'd0, oe_seen}, 8'h01);
        check("R8 oe released after frame", {7'd0, spi_miso_oe}, 8'h00);
        cs_low();
        xfer(8'h05, 8, d);
        xfer(8'h00, 8, d);
        xfer(8'h00, 8, v);
        cs_high();
        check("R8 status repeats in second byte", v, 8'h05);
        array_busy = 1'b0;
        cs_low();
        xfer(8'h06, 8, d);
        xfer(8'h00, 8, d);
        check("R8 oe low for non-read command", {7'd0, oe_seen}, 8'h00);
        cs_high();
    endtask

    task automatic t_otp();
        logic [7:0] v;
        cmd1(8'hB1);
        check("R10 enter otp", {7'd0, otp_mode}, 8'h01);
        check("R13 no program with bp set", {7'd0, otp_prog_ok}, 8'h00);
        cmd1(8'h04);
        check("R12 write-disable leaves otp", {7'd0, otp_mode}, 8'h00);
        cmd1(8'h06);
        wrsr(8'h00);
        cmd1(8'hB1);
        check("R13 program allowed with bp clear", {7'd0, otp_prog_ok}, 8'h01);
        wrsr(8'h9C);
        check("R3 otp write needs enable", {7'd0, otp_prog_ok}, 8'h01);
        cmd1(8'h06);
        check("R12 enable keeps otp mode", {7'd0, otp_mode}, 8'h01);
        wrsr(8'h9C);
        check("R11 otp write seals sector", {7'd0, otp_prog_ok}, 8'h00);
        read_sr(v);
        check("R11 otp write data discarded", v, 8'h00);
        check("R12 read keeps otp mode", {7'd0, otp_mode}, 8'h01);
        cmd1(8'h04);
        check("R12 exit after seal", {7'd0, otp_mode}, 8'h00);
        cmd1(8'hB1);
        check("R11 seal survives re-entry", {7'd0, otp_prog_ok}, 8'h00);
        cmd1(8'h04);
    endtask

    initial begin
        #50;
        rst_n = 1'b1;
        #50;
        t_reset();
        t_enable_rules();
        t_wp_lock();
        t_abort();
        t_read_path();
        t_otp();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule